// File: doc/BRIEF.md
# Carry-Save Alignment Shifter with Shared Rounding Mask

This block is the alignment stage of a partially overlapped fused multiply-add datapath. In fused mode it takes the sum and carry vectors that leave the multiplier's reduction tree. Both vectors are shifted right by the same distance into a window twice their width, so no bit shifted past the original least significant position is lost. In plain-add mode the same two shifters align two addend operands instead.

A single thermometer mask is derived from the shift distance. The mask is 1 at and above the position where the original LSB lands and 0 below it. The same mask does two jobs. First, ANDed with the shifted-out region of both shifted vectors, it yields one shared sticky bit. Second, its lowest set bit marks the moved carry point, where the multiplier-side rounding constant (0..3) is re-placed at its new weight. Together these give an aggregate rounding-constant vector for the downstream 4:2 compressor.

The block also classifies the operation into one of six alignment cases. It provides the short-path addend alignment, a 3:1 selection of shifts 0, 1 or 2, used when the product exponent leads by at most two. All results are registered once.

Top module: `fma_align_shift`

## Requirements
- R1: All outputs come from one register stage and change one clock edge after the inputs are sampled. An active-low asynchronous reset clears every output to zero, including the case code.
- R2: Each shifted output equals its N-bit input placed in the upper half of a 2N-bit field with zeros below, then shifted right by the effective distance. Both vectors use the same distance.
- R3: The effective distance is the shift input clamped to N, so any request above N gives the same result as a request of exactly N.
- R4: Sticky is the OR of the low N bits of both shifted vectors, which are the bits moved below the original LSB. It is 0 whenever the effective distance is 0.
- R5: In fused mode, with a rounding mode other than toward-zero, the rounding-constant output equals the 2-bit multiplier constant shifted left by N minus the effective distance.
- R6: In plain-add mode (plain-add input = 1) the rounding-constant output is zero whatever the multiplier constant is.
- R7: Rounding-mode encoding: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf. Under 01 the rounding-constant output is zero.
- R8: Case code (3 bits), with d = product exponent minus addend exponent as a signed value: 1 = add and d>0; 2 = add and d<=0; 3 = subtract and 0<=d<=2; 4 = subtract and d>2; 5 = subtract and -2<=d<0; 6 = subtract and d<-2.
- R9: The short-path addend output (N+2 bits) is the addend followed by two zero bits, shifted right by d when 0<=d<=2, and zero for any other d.
- R10: When the effective distance is at least 3, the rounding-constant output stays below 2^(N-1). This is the bounded rounding fraction of the far path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| plain_add_i | input | 1 | 1: align two addends, 0: align sum/carry pair |
| rnd_mode_i | input | 2 | Rounding mode (R7 encoding) |
| rmul_i | input | 2 | Multiplier-side rounding constant, 0..3 |
| vec_a_i | input | N | Sum vector or first addend |
| vec_b_i | input | N | Carry vector or second addend |
| shamt_i | input | $clog2(N+1) | Requested right-shift distance |
| eff_sub_i | input | 1 | Effective operation is a subtraction |
| exp_diff_i | input | EW | Signed product-minus-addend exponent difference |
| addend_i | input | N | Addend for short-path alignment |
| vec_a_o | output | 2N | Shifted first vector |
| vec_b_o | output | 2N | Shifted second vector |
| sticky_o | output | 1 | Shared sticky bit |
| rconst_o | output | 2N | Aggregate rounding-constant vector |
| case_o | output | 3 | Alignment case code |
| near_o | output | N+2 | Short-path aligned addend |

## Verification
Every result is combinational from the inputs into the single output register. Each result is therefore due exactly one rising edge after the inputs are applied. The bench changes inputs on the falling edge, lets one rising edge pass, and compares on the following falling edge, so no comparison sits on the edge that updates the outputs. The reset value is checked while reset is held, with no clock edge needed, because the reset is asynchronous.

// File: rtl/fma_align_pkg.sv
package fma_align_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_UP      = 2'b10,
    RND_DOWN    = 2'b11
  } rnd_mode_e;

  typedef enum logic [2:0] {
    CASE_NONE    = 3'd0,
    CASE_ADD_GT  = 3'd1,
    CASE_ADD_LE  = 3'd2,
    CASE_SUB_NP  = 3'd3,
    CASE_SUB_FP  = 3'd4,
    CASE_SUB_NA  = 3'd5,
    CASE_SUB_FA  = 3'd6
  } align_case_e;

endpackage

// File: rtl/fma_align_rshift.sv
// Logarithmic right shifter into a double-width window.
module fma_align_rshift #(
  parameter int N  = 53,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [N-1:0]   din_i,
  input  logic [SW-1:0]  sh_i,
  output logic [2*N-1:0] dout_o
);
  localparam int W = 2 * N;

  logic [W-1:0] stage [SW+1];

  assign stage[0] = {din_i, {N{1'b0}}};

  for (genvar j = 0; j < SW; j++) begin : g_stage
    assign stage[j+1] = sh_i[j] ? (stage[j] >> (1 << j)) : stage[j];
  end

  assign dout_o = stage[SW];

endmodule

// File: rtl/fma_align_mask.sv
// Thermometer mask: 1 at positions >= N - sh, 0 below. Lowest 1 is the carry point.
module fma_align_mask #(
  parameter int N  = 53,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [SW-1:0]  sh_i,
  output logic [2*N-1:0] mask_o,
  output logic [2*N-1:0] unit_o
);
  localparam int W = 2 * N;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign mask_o[k] = (32'(sh_i) + 32'(k)) >= 32'(N);
  end

  assign unit_o = mask_o & ~(mask_o << 1);

endmodule

// File: rtl/fma_align_class.sv
// Case classification and short-path 3:1 addend alignment.
module fma_align_class
  import fma_align_pkg::*;
#(
  parameter int N  = 53,
  parameter int EW = 13
) (
  input  logic          eff_sub_i,
  input  logic [EW-1:0] exp_diff_i,
  input  logic [N-1:0]  addend_i,
  output align_case_e   case_o,
  output logic [N+1:0]  near_o
);
  localparam logic signed [EW-1:0] D0   = EW'(0);
  localparam logic signed [EW-1:0] D1   = EW'(1);
  localparam logic signed [EW-1:0] D2   = EW'(2);
  localparam logic signed [EW-1:0] DM2  = -D2;

  logic signed [EW-1:0] d;
  logic [N+1:0]         base;

  assign d    = $signed(exp_diff_i);
  assign base = {addend_i, 2'b00};

  always_comb begin
    if (!eff_sub_i) begin
      case_o = (d > D0) ? CASE_ADD_GT : CASE_ADD_LE;
    end else if (d >= D0) begin
      case_o = (d <= D2) ? CASE_SUB_NP : CASE_SUB_FP;
    end else begin
      case_o = (d >= DM2) ? CASE_SUB_NA : CASE_SUB_FA;
    end
  end

  always_comb begin
    if (d == D0)      near_o = base;
    else if (d == D1) near_o = base >> 1;
    else if (d == D2) near_o = base >> 2;
    else              near_o = '0;
  end

endmodule

// File: rtl/fma_align_shift.sv
module fma_align_shift
  import fma_align_pkg::*;
#(
  parameter int N  = 53,
  parameter int EW = 13,
  parameter int SW = $clog2(N + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           plain_add_i,
  input  logic [1:0]     rnd_mode_i,
  input  logic [1:0]     rmul_i,
  input  logic [N-1:0]   vec_a_i,
  input  logic [N-1:0]   vec_b_i,
  input  logic [SW-1:0]  shamt_i,
  input  logic           eff_sub_i,
  input  logic [EW-1:0]  exp_diff_i,
  input  logic [N-1:0]   addend_i,
  output logic [2*N-1:0] vec_a_o,
  output logic [2*N-1:0] vec_b_o,
  output logic           sticky_o,
  output logic [2*N-1:0] rconst_o,
  output logic [2:0]     case_o,
  output logic [N+1:0]   near_o
);
  localparam int W = 2 * N;
  localparam logic [SW-1:0] SH_MAX   = SW'(N);
  localparam logic [W-1:0]  LOW_HALF = {{N{1'b0}}, {N{1'b1}}};
  localparam logic [W-1:0]  R_BOUND  = W'(1) << (N - 1);

  logic [SW-1:0] sh_eff;
  logic [N-1:0]  din    [2];
  logic [W-1:0]  dshift [2];
  logic [W-1:0]  mask, unit;
  logic [1:0]    rmul_eff;
  logic [W-1:0]  rconst_d;
  logic          sticky_d;
  align_case_e   case_d;
  logic [N+1:0]  near_d;

  assign sh_eff = (shamt_i > SH_MAX) ? SH_MAX : shamt_i;
  assign din[0] = vec_a_i;
  assign din[1] = vec_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_shf
    fma_align_rshift #(.N(N), .SW(SW)) u_shf (
      .din_i  (din[g]),
      .sh_i   (sh_eff),
      .dout_o (dshift[g])
    );
  end

  fma_align_mask #(.N(N), .SW(SW)) u_mask (
    .sh_i   (sh_eff),
    .mask_o (mask),
    .unit_o (unit)
  );

  // One mask window serves both shifters for sticky.
  assign sticky_d = |((dshift[0] | dshift[1]) & mask & LOW_HALF);

  // Multiplier constant is a count of unit masks; bit1 weighs two units.
  assign rmul_eff = (plain_add_i || rnd_mode_i == RND_ZERO) ? 2'b00 : rmul_i;
  assign rconst_d = ({W{rmul_eff[0]}} & unit) | ({W{rmul_eff[1]}} & (unit << 1));

  fma_align_class #(.N(N), .EW(EW)) u_class (
    .eff_sub_i  (eff_sub_i),
    .exp_diff_i (exp_diff_i),
    .addend_i   (addend_i),
    .case_o     (case_d),
    .near_o     (near_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_a_o  <= '0;
      vec_b_o  <= '0;
      sticky_o <= 1'b0;
      rconst_o <= '0;
      case_o   <= CASE_NONE;
      near_o   <= '0;
    end else begin
      vec_a_o  <= dshift[0];
      vec_b_o  <= dshift[1];
      sticky_o <= sticky_d;
      rconst_o <= rconst_d;
      case_o   <= case_d;
      near_o   <= near_d;
    end
  end

  a_r4_no_sticky_unshifted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(shamt_i) == '0) |-> !sticky_o);

  a_r6_plain_no_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(plain_add_i) |-> (rconst_o == '0));

  a_r7_trunc_no_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rnd_mode_i) == RND_ZERO) |-> (rconst_o == '0));

  a_r8_case_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (case_o >= 3'd1 && case_o <= 3'd6));

  a_r10_far_const_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(shamt_i) >= SW'(3)) |-> (rconst_o < R_BOUND));

  a_r2_shift_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($countones(vec_a_o) == $countones($past(vec_a_i))));

endmodule

// File: tb/tb_fma_align_shift.sv
module tb_fma_align_shift;
  localparam int N      = 8;
  localparam int EW     = 6;
  localparam int SW     = $clog2(N + 1);
  localparam int W      = 2 * N;
  localparam int PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           plain;
  logic [1:0]     rnd, rmul;
  logic [N-1:0]   a, b, addend;
  logic [SW-1:0]  sh;
  logic           sub;
  logic [EW-1:0]  diff;
  logic [W-1:0]   a_o, b_o, rc_o;
  logic           st_o;
  logic [2:0]     cs_o;
  logic [N+1:0]   nr_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD / 2) clk = ~clk;

  fma_align_shift #(.N(N), .EW(EW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .plain_add_i(plain), .rnd_mode_i(rnd),
    .rmul_i(rmul), .vec_a_i(a), .vec_b_i(b), .shamt_i(sh), .eff_sub_i(sub),
    .exp_diff_i(diff), .addend_i(addend), .vec_a_o(a_o), .vec_b_o(b_o),
    .sticky_o(st_o), .rconst_o(rc_o), .case_o(cs_o), .near_o(nr_o)
  );

  // {plain, rnd, rmul, a, b, sub, diff, addend, exp_case, exp_near}
  localparam int TW = 1 + 2 + 2 + 8 + 8 + 1 + 6 + 8 + 3 + 10;
  localparam logic [TW-1:0] TBL [9] = '{
    {1'b0, 2'd0, 2'd3, 8'hA5, 8'h3C, 1'b0, 6'd3,  8'hFF, 3'd1, 10'h000},
    {1'b0, 2'd2, 2'd1, 8'h01, 8'h80, 1'b0, 6'd0,  8'h81, 3'd2, 10'h204},
    {1'b0, 2'd1, 2'd2, 8'hFF, 8'hFF, 1'b1, 6'd1,  8'h81, 3'd3, 10'h102},
    {1'b0, 2'd3, 2'd2, 8'h0F, 8'hF0, 1'b1, 6'd2,  8'hC3, 3'd3, 10'h0C3},
    {1'b1, 2'd0, 2'd3, 8'h5A, 8'h96, 1'b1, 6'd7,  8'h55, 3'd4, 10'h000},
    {1'b0, 2'd0, 2'd3, 8'h80, 8'h01, 1'b1, 6'h3F, 8'h11, 3'd5, 10'h000},
    {1'b0, 2'd2, 2'd0, 8'h33, 8'hCC, 1'b1, 6'h3E, 8'h22, 3'd5, 10'h000},
    {1'b1, 2'd3, 2'd1, 8'h7E, 8'h00, 1'b1, 6'h3D, 8'h44, 3'd6, 10'h000},
    {1'b0, 2'd0, 2'd1, 8'h00, 8'h00, 1'b0, 6'h20, 8'h99, 3'd2, 10'h000}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clampsh(input int s);
    return (s > N) ? N : s;
  endfunction

  function automatic logic [W-1:0] mshift(input logic [N-1:0] v, input int s);
    return {v, {N{1'b0}}} >> clampsh(s);
  endfunction

  function automatic logic [W-1:0] mconst(input logic p, input logic [1:0] rm,
                                          input logic [1:0] rk, input int s);
    if (p || rm == 2'b01) return '0;
    return W'(rk) << (N - clampsh(s));
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic print_summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    print_summary();
    $finish;
  end

  initial begin
    plain = 0; rnd = 0; rmul = 3; a = 8'hFF; b = 8'hFF; addend = 8'hFF;
    sh = 4'd3; sub = 0; diff = 6'd1;
    #(PERIOD * 2 + 1);
    // R1: reset state
    chk("R1 reset vec_a", a_o, '0);
    chk("R1 reset rconst", rc_o, '0);
    chk("R1 reset case", W'(cs_o), '0);
    chk("R1 reset sticky", W'(st_o), '0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      logic [TW-1:0] e = TBL[i];
      for (int s = 0; s < 16; s++) begin
        logic [W-1:0] ea, eb;
        {plain, rnd, rmul, a, b, sub, diff, addend} = e[TW-1:13];
        sh = SW'(s);
        ea = mshift(a, s);
        eb = mshift(b, s);
        step();
        chk("R2 R3 vec_a", a_o, ea);
        chk("R2 R3 vec_b", b_o, eb);
        chk("R4 sticky", W'(st_o), W'(|((ea | eb) & W'({N{1'b1}}))));
        chk("R5 R6 R7 rconst", rc_o, mconst(plain, rnd, rmul, s));
        chk("R8 case", W'(cs_o), W'(e[12:10]));
        chk("R9 near", W'(nr_o), W'(e[9:0]));
      end
    end

    // R3: over-range request equals exactly N
    plain = 0; rnd = 2'b10; rmul = 2'd3; a = 8'hC1; b = 8'h3E; sh = 4'd15;
    step();
    chk("R3 clamp vec_a", a_o, 16'h00C1);
    chk("R3 clamp rconst", rc_o, 16'h0003);
    chk("R4 sticky full shift", W'(st_o), W'(1));

    // R10: far path constant bound at shift 3, maximal constant
    sh = 4'd3; rmul = 2'd3;
    step();
    chk("R10 far bound", rc_o, 16'h0060);
    chk("R10 below half", W'(rc_o < 16'h0080), W'(1));

    // R4: zero shift means zero sticky even with full inputs
    sh = 4'd0; a = 8'hFF; b = 8'hFF;
    step();
    chk("R4 no shift sticky", W'(st_o), W'(0));
    chk("R5 no shift rconst", rc_o, 16'h0300);

    // R6: plain mode ignores constant, outputs still shifted
    plain = 1; sh = 4'd2;
    step();
    chk("R6 plain rconst", rc_o, '0);
    chk("R6 plain vec_a", a_o, 16'h3FC0);

    // R1: asynchronous reset clears outputs mid-run
    #(PERIOD / 4);
    rst_n = 1'b0;
    #1;
    chk("R1 async vec_a", a_o, '0);
    chk("R1 async near", W'(nr_o), '0);
    chk("R1 async case", W'(cs_o), '0);

    print_summary();
    $finish;
  end

endmodule